// File: doc/BRIEF.md
# Tapped Programmable Reference Divider

This block slows a reference clock before it reaches a pair of phase comparators. A down-counter divides the reference by a programmable ratio R. Each terminal count of that counter then advances a binary chain of four halving stages. This gives five taps, at R, 2R, 4R, 8R and 16R reference cycles per pulse. Two independent 3-bit selector codes each pick one tap. The main selector drives the main comparator input. The auxiliary selector drives the auxiliary comparator input and decodes its code in reverse order.

A small controller with three states sequences the block. ST_OFF holds everything idle while `enable` is low. ST_LOAD lasts one cycle: it presets the counter to R-1 and clears the halving chain. ST_RUN counts. The transitions are as follows:
- ST_OFF goes to ST_LOAD when `enable` rises.
- ST_LOAD goes to ST_RUN when `enable` is high and no resync is requested.
- ST_LOAD stays in ST_LOAD while `resync` is held.
- ST_RUN goes to ST_LOAD on `resync`.
- ST_LOAD and ST_RUN both go to ST_OFF when `enable` falls.

Every start therefore begins from the same phase. This lets the divider line up with the feedback divider when the loop comes out of power-down.

Top module: `ref_tap_divider`

## Requirements
- R1: Let edge 0 be the first clock edge that samples `enable` high in ST_OFF, or `resync` high in ST_RUN. The tap-0 pulse (divide by R) first appears after edge R+1 and repeats every R cycles, for any R from 4 to 1023.
- R2: Tap k (k = 0..4) divides by R·2^k. Its first pulse appears after edge R·2^k+1 and repeats every R·2^k cycles.
- R3: `main_sel` codes 000, 001, 010, 011 and 100 select taps 0, 1, 2, 3 and 4 (R, 2R, 4R, 8R, 16R) onto `main_pulse`.
- R4: `aux_sel` codes 100, 011, 010, 001 and 000 select taps 0, 1, 2, 3 and 4 onto `aux_pulse`.
- R5: Selector codes 101, 110 and 111 act as code 100. For the main selector this means tap 4 (16R); for the auxiliary selector it means tap 0 (R).
- R6: A `ratio` value below 4 divides as if it were 4.
- R7: Each output pulse is high for exactly one reference cycle.
- R8: A change on `ratio` does not disturb the period in progress. It takes effect at the next terminal count of the programmable counter.
- R9: While `enable` is low, both outputs stay low. Raising `enable` again restarts with the timing of R1 and R2.
- R10: A one-cycle `resync` while running restarts the counter and the halving chain. The timing of R1 and R2 then applies from that edge.
- R11: During and after reset, with `enable` low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low means powered down |
| resync | input | 1 | Restart request, one cycle |
| ratio | input | 10 | Programmable division ratio R |
| main_sel | input | 3 | Tap code for the main output |
| aux_sel | input | 3 | Tap code for the auxiliary output, reversed order |
| main_pulse | output | 1 | One-cycle pulse at the main selected rate |
| aux_pulse | output | 1 | One-cycle pulse at the auxiliary selected rate |

## Verification
The vector table pairs main and auxiliary codes so that every tap is reached from both selectors. Each vector measures the first-pulse latency and the repeat period. The latency checks that the halving chain starts cleared. The period checks that the ratio and the tap depth are right. Some vectors set the two selectors to different taps, which tells a reversed decode apart from a shared one. Out-of-range codes and ratios below the floor each get their own vector. A maximum ratio exercises the full counter width. Directed runs change the ratio in the middle of a period, drop and restore `enable`, and issue a resync from a running state. These three separate a deferred reload from an immediate one, and a true restart from a free-running count.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } run_state_t;
endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
    import refdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic resync,
    output logic load,
    output logic run
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (enable) state_d = ST_LOAD;
            ST_LOAD: begin
                if (!enable)     state_d = ST_OFF;
                else if (!resync) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!enable)     state_d = ST_OFF;
                else if (resync) state_d = ST_LOAD;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        load = (state_q == ST_LOAD);
        run  = (state_q == ST_RUN);
    end

    // R10: a resync seen while running always leads to a load cycle
    assert_resync_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && enable && resync) |=> load);
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
    parameter int RW   = 10,
    parameter int RMIN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [RW-1:0] ratio,
    output logic          tc
);
    localparam logic [RW-1:0] FLOOR    = RW'(RMIN);
    localparam logic [RW-1:0] FLOOR_M1 = RW'(RMIN - 1);

    logic [RW-1:0] cnt_q;
    logic [RW-1:0] eff_ratio;
    logic [RW-1:0] preset;

    always_comb begin
        eff_ratio = (ratio < FLOOR) ? FLOOR : ratio;
        preset    = eff_ratio - 1'b1;
        tc        = run && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= preset;
        else if (run) begin
            if (cnt_q == '0) cnt_q <= preset;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_reload_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (cnt_q >= FLOOR_M1));
endmodule

// File: rtl/refdiv_prescale.sv
module refdiv_prescale #(
    parameter int HALVERS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tc,
    output logic [HALVERS:0] taps
);
    logic [HALVERS-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    chain_q <= '0;
        else if (load) chain_q <= '0;
        else if (tc)   chain_q <= chain_q + 1'b1;
    end

    assign taps[0] = tc;
    for (genvar k = 1; k <= HALVERS; k++) begin : g_tap
        assign taps[k] = tc && (&chain_q[k-1:0]);
    end

    // R2: the halving chain only moves on a terminal count or a restart
    assert_chain_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc && !load) |=> $stable(chain_q));
endmodule

// File: rtl/refdiv_tap_select.sv
module refdiv_tap_select #(
    parameter int TAPS    = 5,
    parameter int SELW    = 3,
    parameter bit REVERSE = 1'b0
) (
    input  logic [SELW-1:0] sel,
    input  logic [TAPS-1:0] taps,
    output logic            hit
);
    localparam logic [SELW-1:0] LAST = SELW'(TAPS - 1);

    logic [SELW-1:0] code;
    logic [SELW-1:0] idx;

    always_comb code = (sel > LAST) ? LAST : sel;

    if (REVERSE) begin : g_rev
        always_comb idx = LAST - code;
    end else begin : g_fwd
        always_comb idx = code;
    end

    always_comb hit = taps[idx];
endmodule

// File: rtl/ref_tap_divider.sv
module ref_tap_divider #(
    parameter int RATIO_W   = 10,
    parameter int RATIO_MIN = 4,
    parameter int HALVERS   = 4,
    parameter int SEL_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               resync,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [SEL_W-1:0]   main_sel,
    input  logic [SEL_W-1:0]   aux_sel,
    output logic               main_pulse,
    output logic               aux_pulse
);
    localparam int TAPS = HALVERS + 1;

    logic            load, run, tc;
    logic [TAPS-1:0] taps;
    logic            main_hit, aux_hit;

    refdiv_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .resync(resync),
        .load(load), .run(run)
    );

    refdiv_counter #(.RW(RATIO_W), .RMIN(RATIO_MIN)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .run(run),
        .ratio(ratio), .tc(tc)
    );

    refdiv_prescale #(.HALVERS(HALVERS)) u_pre (
        .clk(clk), .rst_n(rst_n), .load(load), .tc(tc), .taps(taps)
    );

    refdiv_tap_select #(.TAPS(TAPS), .SELW(SEL_W), .REVERSE(1'b0)) u_main (
        .sel(main_sel), .taps(taps), .hit(main_hit)
    );

    refdiv_tap_select #(.TAPS(TAPS), .SELW(SEL_W), .REVERSE(1'b1)) u_aux (
        .sel(aux_sel), .taps(taps), .hit(aux_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_pulse <= 1'b0;
            aux_pulse  <= 1'b0;
        end else begin
            main_pulse <= enable && main_hit;
            aux_pulse  <= enable && aux_hit;
        end
    end

    assert_main_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        main_pulse |=> !main_pulse);

    assert_aux_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        aux_pulse |=> !aux_pulse);

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!main_pulse && !aux_pulse));
endmodule

// File: tb/sim_ref_tap_divider.sv
module sim_ref_tap_divider;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    // ratio, main code, aux code, main first/period, aux first/period
    localparam int V_R  [NV] = '{4, 5, 6, 7, 4, 5, 2, 1023};
    localparam int V_MS [NV] = '{0, 1, 2, 3, 4, 6, 0, 0};
    localparam int V_AS [NV] = '{4, 3, 0, 1, 2, 7, 2, 4};
    localparam int V_MF [NV] = '{5, 11, 25, 57, 65, 81, 5, 1024};
    localparam int V_MP [NV] = '{4, 10, 24, 56, 64, 80, 4, 1023};
    localparam int V_AF [NV] = '{5, 11, 97, 57, 17, 6, 17, 1024};
    localparam int V_AP [NV] = '{4, 10, 96, 56, 16, 5, 16, 1023};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       resync = 1'b0;
    logic [9:0] ratio = 10'd4;
    logic [2:0] main_sel = 3'd0;
    logic [2:0] aux_sel = 3'd0;
    logic       main_pulse, aux_pulse;

    int nchk = 0;
    int nfail = 0;

    ref_tap_divider u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .resync(resync),
        .ratio(ratio), .main_sel(main_sel), .aux_sel(aux_sel),
        .main_pulse(main_pulse), .aux_pulse(aux_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stimulus was changed at the preceding negedge; edge 0 is the next posedge.
    task automatic measure(input int lim, output int mf, output int ms,
                           output int af, output int as_, output int wide);
        logic pm = 1'b0, pa = 1'b0;
        mf = -1; ms = -1; af = -1; as_ = -1; wide = 0;
        for (int n = 0; n <= lim; n++) begin
            @(posedge clk);
            @(negedge clk);
            resync = 1'b0;
            if (n >= 1) begin
                if ((main_pulse && pm) || (aux_pulse && pa)) wide++;
                if (main_pulse) begin
                    if (mf < 0) mf = n; else if (ms < 0) ms = n;
                end
                if (aux_pulse) begin
                    if (af < 0) af = n; else if (as_ < 0) as_ = n;
                end
                pm = main_pulse;
                pa = aux_pulse;
                if (ms >= 0 && as_ >= 0) break;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int mf, ms, af, as_, wide, cnt;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 main in reset", int'(main_pulse), 0);
        chk("R11 aux in reset", int'(aux_pulse), 0);
        rst_n = 1'b1;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (main_pulse || aux_pulse) cnt++;
        end
        chk("R11 idle after reset", cnt, 0);

        // Table: R1 R2 R3 R4 (taps), R5 (codes 110/111), R6 (ratio 2), R7 (width)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            enable = 1'b0;
            ratio = 10'(V_R[v]);
            main_sel = 3'(V_MS[v]);
            aux_sel = 3'(V_AS[v]);
            repeat (2) @(negedge clk);
            enable = 1'b1;
            measure(2200, mf, ms, af, as_, wide);
            chk($sformatf("R1 R2 R3 R5 R6 v%0d main first", v), mf, V_MF[v]);
            chk($sformatf("R2 R3 R5 R6 v%0d main period", v), ms - mf, V_MP[v]);
            chk($sformatf("R1 R2 R4 R5 R6 v%0d aux first", v), af, V_AF[v]);
            chk($sformatf("R2 R4 R5 R6 v%0d aux period", v), as_ - af, V_AP[v]);
            chk($sformatf("R7 v%0d pulse width", v), wide, 0);
        end

        // R8: ratio change mid-period applies from the next terminal count
        @(negedge clk);
        enable = 1'b0; ratio = 10'd5; main_sel = 3'd0; aux_sel = 3'd4;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        mf = -1; ms = -1; af = -1;
        for (int n = 0; n <= 40; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (main_pulse) begin
                if (mf < 0) begin mf = n; ratio = 10'd7; end
                else if (ms < 0) ms = n;
                else if (af < 0) af = n;
            end
        end
        chk("R8 first pulse old ratio", mf, 6);
        chk("R8 period in progress keeps old ratio", ms - mf, 5);
        chk("R8 new ratio after terminal count", af - ms, 7);

        // R9: enable low silences outputs; re-enable restarts aligned
        @(negedge clk);
        enable = 1'b0; ratio = 10'd4; main_sel = 3'd0; aux_sel = 3'd4;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (main_pulse || aux_pulse) cnt++;
        end
        chk("R9 no pulses while disabled", cnt, 0);
        enable = 1'b1;
        measure(200, mf, ms, af, as_, wide);
        chk("R9 restart first pulse", mf, 5);
        chk("R9 restart aux first pulse", af, 5);

        // R10: resync restarts counter and halving chain
        @(negedge clk);
        enable = 1'b0; ratio = 10'd6; main_sel = 3'd1; aux_sel = 3'd4;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        repeat (23) @(negedge clk);
        resync = 1'b1;
        measure(200, mf, ms, af, as_, wide);
        chk("R10 main first after resync", mf, 13);
        chk("R10 main period after resync", ms - mf, 12);
        chk("R10 aux first after resync", af, 7);
        chk("R10 pulse width", wide, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule